// File: doc/BRIEF.md
# Boot Chip-Select Decoder

This block drives the active-low chip-select for the memory that holds a processor's startup code on a 24-bit address bus. It compares each bus address against a programmable base. A programmable block-size code masks the low address bits out of that compare. A match counts only if the access type, the byte lanes, the privilege level and the selected strobe all qualify it. Once the chip-select is asserted, the block counts a programmable number of wait states and then pulses its own active-low transfer acknowledge.

Two registers hold the configuration, a base register and an option register, and both are written through a 16-bit write port. Their reset values already select a 512 KB window at address zero. That window accepts reads and writes on both byte lanes, in supervisor mode only, with 13 wait states. The first instruction fetch after reset therefore completes before any software has run.

Each bus cycle takes a snapshot of the configuration when it starts. A register write made while a cycle is in progress applies from the next cycle onward.

Top module: `bootcs_top`

## Requirements
- R1: After reset the base register reads 0x0006 and the option register reads 0x05AF. A supervisor read at address 0x000000 or 0x07FFFF therefore asserts the chip-select, and an access at 0x080000 does not.
- R2: `csN` goes low at the clock edge after the one that first sees the selected strobe asserted with a qualifying match. It returns high at the first clock edge that sees that strobe negated. `csN` never falls unless a strobe was asserted in the cycle before.
- R3: The base register holds the block-size code in bits [2:0]. Codes 0 to 7 select 2 KB, 8 KB, 16 KB, 64 KB, 128 KB, 256 KB, 512 KB and 1 MB. Address bits below 11, 13, 14, 16, 17, 18, 19 and 20 respectively are left out of the compare.
- R4: Base register bits [15:3] are compared with address bits [23:11], with only the bits that the block size keeps taking part.
- R5: Option bits [10:9] select the privilege level: bit 9 enables user accesses (`superMode`=0) and bit 10 enables supervisor accesses.
- R6: Option bits [3:2] select the access type: bit 2 enables reads (`rdWrN`=1) and bit 3 enables writes.
- R7: Option bits [1:0] select the byte lanes: bit 0 enables the lower lane and bit 1 the upper lane. An access qualifies when any lane it enables is selected.
- R8: Option bit 4 selects the qualifying strobe: 0 selects `asN` and 1 selects `dsN`. The other strobe has no effect.
- R9: Option bits [8:5] hold the wait code w. For w from 0 to 13, `dtackN` goes low for exactly one clock, w+1 clocks after `csN` falls.
- R10: Wait code 14 drives `dtackN` low in the same clock that `csN` falls, for one clock. Wait code 15 never drives `dtackN` low.
- R11: A register write made during a cycle changes neither that cycle's acknowledge timing nor its end. It takes effect from the next cycle.
- R12: `dtackN` is low at most once per cycle and only while `csN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write enable |
| regSel | input | 1 | Register select: 0 base, 1 option |
| regWrData | input | 16 | Register write data |
| busAddr | input | 24 | Bus address |
| rdWrN | input | 1 | 1 read, 0 write |
| upperByteEn | input | 1 | Upper byte lane enabled by access |
| lowerByteEn | input | 1 | Lower byte lane enabled by access |
| superMode | input | 1 | 1 supervisor, 0 user access |
| asN | input | 1 | Address strobe, active low |
| dsN | input | 1 | Data strobe, active low |
| csN | output | 1 | Chip-select, active low |
| dtackN | output | 1 | Transfer acknowledge, active low |

## Verification
A wrong mask or base compare shows up in the first clock after the strobe: `csN` stays high when it should fall, or falls when it should stay high. A wrong wait counter or snapshot shows up on `dtackN`, which goes low in the wrong clock, goes low twice, or never goes low. The bench catches these by recording the exact clock of each acknowledge within 20 clocks of the strobe. A state machine that fails to end its cycle keeps `csN` low one clock past the strobe's negation, and that clock is sampled on every matching cycle.

// File: rtl/bootcs_pkg.sv
package bootcs_pkg;
  localparam int ADDR_W      = 24;
  localparam int REG_W       = 16;
  localparam int MIN_BLK_LOG = 11;
  localparam int CMP_W       = ADDR_W - MIN_BLK_LOG;
  localparam int SIZE_W      = 3;
  localparam int WAIT_W      = 4;
  localparam int OPT_W       = 11;

  // option register field positions
  localparam int LANE_LSB   = 0;
  localparam int ACC_LSB    = 2;
  localparam int STRB_BIT   = 4;
  localparam int WAIT_LSB   = 5;
  localparam int SPACE_LSB  = 9;

  localparam logic [WAIT_W-1:0] WAIT_FAST = 4'd14;
  localparam logic [WAIT_W-1:0] WAIT_NONE = 4'd15;

  localparam logic [REG_W-1:0] BASE_RST = 16'h0006;
  localparam logic [OPT_W-1:0] OPT_RST  = 11'h5AF;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
  } ctlStrobe_t;

  typedef enum logic {ST_IDLE, ST_ACTIVE} cycState_t;

  function automatic int ignoredBits(input logic [SIZE_W-1:0] code);
    case (code)
      3'd0: return 11;
      3'd1: return 13;
      3'd2: return 14;
      3'd3: return 16;
      3'd4: return 17;
      3'd5: return 18;
      3'd6: return 19;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/bootcs_datapath.sv
module bootcs_datapath
  import bootcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdWrN,
  input  logic              upperByteEn,
  input  logic              lowerByteEn,
  input  logic              superMode,
  input  logic              asN,
  input  logic              dsN,
  input  ctlStrobe_t        ctl,
  output logic              hitNow,
  output logic              strobeNow,
  output logic              strobeAct,
  output logic              fastNow,
  output logic              cntZero,
  output logic              actNoAck
);
  logic [REG_W-1:0]  baseQ;
  logic [OPT_W-1:0]  optQ;
  logic [WAIT_W-1:0] cntQ;
  logic [WAIT_W-1:0] actWaitQ;
  logic              actDsQ;
  logic [CMP_W-1:0]  cmpMask;
  logic              unusedOptBits;

  assign unusedOptBits = ^regWrData[REG_W-1:OPT_W];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= BASE_RST;
      optQ  <= OPT_RST;
    end else if (regWrEn) begin
      if (regSel) optQ  <= regWrData[OPT_W-1:0];
      else        baseQ <= regWrData;
    end
  end

  // per-bit compare mask from block size code
  for (genvar i = 0; i < CMP_W; i++) begin : g_mask
    assign cmpMask[i] = (i + MIN_BLK_LOG) >= ignoredBits(baseQ[SIZE_W-1:0]);
  end

  logic [WAIT_W-1:0] waitCode;
  logic [1:0] laneSel, accSel, spaceSel;
  logic addrHit, laneOk, accOk, spaceOk;

  always_comb begin
    waitCode = optQ[WAIT_LSB +: WAIT_W];
    laneSel  = optQ[LANE_LSB +: 2];
    accSel   = optQ[ACC_LSB +: 2];
    spaceSel = optQ[SPACE_LSB +: 2];
    addrHit  = ((busAddr[ADDR_W-1:MIN_BLK_LOG] ^ baseQ[REG_W-1:SIZE_W]) & cmpMask) == '0;
    laneOk   = (upperByteEn & laneSel[1]) | (lowerByteEn & laneSel[0]);
    accOk    = rdWrN ? accSel[0] : accSel[1];
    spaceOk  = superMode ? spaceSel[1] : spaceSel[0];
    hitNow   = addrHit & laneOk & accOk & spaceOk;
    strobeNow = optQ[STRB_BIT] ? !dsN : !asN;
    strobeAct = actDsQ ? !dsN : !asN;
    fastNow  = waitCode == WAIT_FAST;
    cntZero  = cntQ == '0;
    actNoAck = actWaitQ == WAIT_NONE;
  end

  // cycle snapshot and wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ     <= '0;
      actWaitQ <= '0;
      actDsQ   <= 1'b0;
    end else if (ctl.loadCnt) begin
      cntQ     <= waitCode;
      actWaitQ <= waitCode;
      actDsQ   <= optQ[STRB_BIT];
    end else if (ctl.decCnt) begin
      cntQ <= cntQ - 1'b1;
    end
  end
endmodule

// File: rtl/bootcs_control.sv
module bootcs_control
  import bootcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hitNow,
  input  logic       strobeNow,
  input  logic       strobeAct,
  input  logic       fastNow,
  input  logic       cntZero,
  input  logic       actNoAck,
  output ctlStrobe_t ctl,
  output logic       csN,
  output logic       dtackN
);
  cycState_t stateQ;
  logic strobePrevQ, ackedQ, csNQ, dtackNQ;
  logic startCycle, endCycle, fireAck;

  always_comb begin
    startCycle  = (stateQ == ST_IDLE) && strobeNow && !strobePrevQ && hitNow;
    endCycle    = (stateQ == ST_ACTIVE) && !strobeAct;
    fireAck     = (stateQ == ST_ACTIVE) && !endCycle && cntZero && !ackedQ && !actNoAck;
    ctl.loadCnt = startCycle;
    ctl.decCnt  = (stateQ == ST_ACTIVE) && !cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      strobePrevQ <= 1'b0;
      ackedQ      <= 1'b0;
      csNQ        <= 1'b1;
      dtackNQ     <= 1'b1;
    end else begin
      strobePrevQ <= strobeNow;
      dtackNQ     <= !((startCycle && fastNow) || fireAck);
      if (startCycle) begin
        stateQ <= ST_ACTIVE;
        csNQ   <= 1'b0;
        ackedQ <= fastNow;
      end else if (endCycle) begin
        stateQ <= ST_IDLE;
        csNQ   <= 1'b1;
        ackedQ <= 1'b0;
      end else if (fireAck) begin
        ackedQ <= 1'b1;
      end
    end
  end

  assign csN    = csNQ;
  assign dtackN = dtackNQ;
endmodule

// File: rtl/bootcs_top.sv
module bootcs_top
  import bootcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              rdWrN,
  input  logic              upperByteEn,
  input  logic              lowerByteEn,
  input  logic              superMode,
  input  logic              asN,
  input  logic              dsN,
  output logic              csN,
  output logic              dtackN
);
  ctlStrobe_t ctl;
  logic hitNow, strobeNow, strobeAct, fastNow, cntZero, actNoAck;

  bootcs_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .busAddr(busAddr), .rdWrN(rdWrN),
    .upperByteEn(upperByteEn), .lowerByteEn(lowerByteEn),
    .superMode(superMode), .asN(asN), .dsN(dsN), .ctl(ctl),
    .hitNow(hitNow), .strobeNow(strobeNow), .strobeAct(strobeAct),
    .fastNow(fastNow), .cntZero(cntZero), .actNoAck(actNoAck)
  );

  bootcs_control u_ctl (
    .clk(clk), .rstN(rstN), .hitNow(hitNow), .strobeNow(strobeNow),
    .strobeAct(strobeAct), .fastNow(fastNow), .cntZero(cntZero),
    .actNoAck(actNoAck), .ctl(ctl), .csN(csN), .dtackN(dtackN)
  );
endmodule

// File: rtl/bootcs_checker.sv
module bootcs_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic dtackN,
  input logic asN,
  input logic dsN
);
  // R12: acknowledge lasts one clock
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    !dtackN |=> dtackN);

  // R12: acknowledge only inside an asserted chip-select
  p_ack_in_cs_r12: assert property (@(posedge clk) disable iff (!rstN)
    !dtackN |-> !csN);

  // R2: chip-select only follows a strobe
  p_cs_after_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(!asN || !dsN));

  // R2: both strobes negated ends the cycle
  p_cs_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && asN && dsN) |=> csN);

  // R1: reset leaves outputs idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (csN && dtackN));
endmodule

bind bootcs_top bootcs_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .dtackN(dtackN), .asN(asN), .dsN(dsN)
);

// File: tb/tb_bootcs_top.sv
module tb_bootcs_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic [23:0] busAddr = '0;
  logic rdWrN = 1'b1, upperByteEn = 1'b1, lowerByteEn = 1'b1, superMode = 1'b1;
  logic asN = 1'b1, dsN = 1'b1;
  logic csN, dtackN;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bootcs_top dut (.*);

  function automatic logic [15:0] mkOpt(input logic [1:0] lane, input logic [1:0] acc,
                                        input logic ds, input logic [3:0] w, input logic [1:0] sp);
    return {5'd0, sp, w, ds, acc, lane};
  endfunction

  function automatic logic [15:0] mkBase(input logic [12:0] fld, input logic [2:0] code);
    return {fld, code};
  endfunction

  typedef struct packed {
    logic [23:0] addr;
    logic rd, up, lo, sup, drvAs, drvDs;
    logic [15:0] base;
    logic [15:0] opt;
    logic expCs;
    logic [5:0] expAck;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{24'h07FFFF,1,1,1,1,1,0, mkBase(0,6), mkOpt(3,3,0,13,2), 1, 14},       // R1
    '{24'h080000,1,1,1,1,1,0, mkBase(0,6), mkOpt(3,3,0,13,2), 0, 63},       // R1
    '{24'h000100,1,1,1,0,1,0, mkBase(0,6), mkOpt(3,3,0,13,2), 0, 63},       // R5
    '{24'h000100,1,1,1,0,1,0, mkBase(0,6), mkOpt(3,3,0,2,1),  1, 3},        // R5
    '{24'h000200,1,1,1,1,1,0, mkBase(0,6), mkOpt(3,3,0,0,3),  1, 1},        // R9
    '{24'h1FFFFF,1,1,1,1,1,0, mkBase(13'h200,7), mkOpt(3,3,0,4,2), 1, 5},   // R4
    '{24'h0FFFFF,1,1,1,1,1,0, mkBase(13'h200,7), mkOpt(3,3,0,4,2), 0, 63},  // R4
    '{24'h1007FF,1,1,1,1,1,0, mkBase(13'h200,0), mkOpt(3,3,0,1,2), 1, 2},   // R3
    '{24'h100800,1,1,1,1,1,0, mkBase(13'h200,0), mkOpt(3,3,0,1,2), 0, 63},  // R3
    '{24'h000010,0,1,1,1,1,0, mkBase(0,6), mkOpt(3,1,0,13,2), 0, 63},       // R6
    '{24'h000010,0,1,1,1,1,0, mkBase(0,6), mkOpt(3,2,0,3,2),  1, 4},        // R6
    '{24'h000020,1,1,0,1,1,0, mkBase(0,6), mkOpt(1,3,0,13,2), 0, 63},       // R7
    '{24'h000020,1,0,1,1,1,0, mkBase(0,6), mkOpt(1,3,0,0,2),  1, 1},        // R7
    '{24'h000020,1,1,0,1,1,0, mkBase(0,6), mkOpt(2,3,0,6,2),  1, 7},        // R7
    '{24'h000040,1,1,1,1,1,0, mkBase(0,6), mkOpt(3,3,0,14,2), 1, 0},        // R10
    '{24'h000040,1,1,1,1,1,0, mkBase(0,6), mkOpt(3,3,0,15,2), 1, 63},       // R10
    '{24'h01ABCD,1,1,1,1,1,0, mkBase(13'h020,3), mkOpt(3,3,0,5,2), 1, 6},   // R3
    '{24'h020000,1,1,1,1,1,0, mkBase(13'h020,3), mkOpt(3,3,0,5,2), 0, 63},  // R3
    '{24'h000080,1,1,1,1,0,1, mkBase(0,6), mkOpt(3,3,1,2,2),  1, 3},        // R8
    '{24'h000080,1,1,1,1,1,0, mkBase(0,6), mkOpt(3,3,1,2,2),  0, 63},       // R8
    '{24'h000080,1,1,1,1,0,1, mkBase(0,6), mkOpt(3,3,0,2,2),  0, 63}        // R8
  };

  function automatic string tagOf(input int idx);
    case (idx)
      0, 1: return "R1";
      2, 3: return "R5";
      4: return "R9";
      5, 6: return "R4";
      7, 8, 16, 17: return "R3";
      9, 10: return "R6";
      11, 12, 13: return "R7";
      14, 15: return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // drives one bus cycle; reports chip-select at the first sample, first ack sample, ack count
  task automatic runCycle(input logic [23:0] a, input logic rd, input logic up, input logic lo,
                          input logic sup, input logic useAs, input logic useDs,
                          output int csSeen, output int ackAt, output int ackCnt, output int csOff);
    @(negedge clk);
    busAddr = a; rdWrN = rd; upperByteEn = up; lowerByteEn = lo; superMode = sup;
    asN = !useAs; dsN = !useDs;
    ackAt = 63; ackCnt = 0; csSeen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 0) csSeen = !csN;
      if (!dtackN) begin
        ackCnt++;
        if (ackAt == 63) ackAt = i;
      end
    end
    asN = 1'b1; dsN = 1'b1;
    @(negedge clk);
    csOff = csN && dtackN;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    int cs, ack, cnt, off;
    repeat (3) @(negedge clk);
    check(csN && dtackN, "R1", "outputs idle in reset", {csN, dtackN}, 3);
    rstN = 1'b1;
    @(negedge clk);
    check(csN && dtackN, "R1", "outputs idle after reset", {csN, dtackN}, 3);

    // reset configuration: address zero, 13 waits, single pulse, release
    runCycle(24'h000000, 1, 1, 1, 1, 1, 0, cs, ack, cnt, off);
    check(cs == 1, "R1", "cs at 0x000000 from reset", cs, 1);
    check(ack == 14, "R9", "ack clock with reset wait code", ack, 14);
    check(cnt == 1, "R12", "ack pulse count", cnt, 1);
    check(off == 1, "R2", "cs released on strobe negation", off, 1);

    for (int v = 0; v < NV; v++) begin
      writeReg(1'b0, VECS[v].base);
      writeReg(1'b1, VECS[v].opt);
      runCycle(VECS[v].addr, VECS[v].rd, VECS[v].up, VECS[v].lo, VECS[v].sup,
               VECS[v].drvAs, VECS[v].drvDs, cs, ack, cnt, off);
      check(cs == int'(VECS[v].expCs), tagOf(v), $sformatf("vec %0d cs", v), cs, VECS[v].expCs);
      check(ack == int'(VECS[v].expAck), tagOf(v), $sformatf("vec %0d ack clock", v), ack, VECS[v].expAck);
      if (VECS[v].expAck != 63)
        check(cnt == 1, "R12", $sformatf("vec %0d ack count", v), cnt, 1);
      check(off == 1, "R2", $sformatf("vec %0d idle after strobe", v), off, 1);
    end

    // R11: mid-cycle write must not retime the cycle in progress
    writeReg(1'b0, mkBase(0, 6));
    writeReg(1'b1, mkOpt(3, 3, 0, 10, 2));
    @(negedge clk);
    busAddr = 24'h000004; rdWrN = 1'b1; upperByteEn = 1'b1; lowerByteEn = 1'b1;
    superMode = 1'b1; asN = 1'b0;
    ack = 63; cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!dtackN) begin
        cnt++;
        if (ack == 63) ack = i;
      end
      if (i == 3) begin
        regWrEn = 1'b1; regSel = 1'b1; regWrData = mkOpt(3, 3, 1, 0, 1);
      end
      if (i == 4) regWrEn = 1'b0;
      if (i == 8) check(!csN, "R11", "cycle held under new strobe select", csN, 0);
    end
    check(ack == 11, "R11", "ack clock kept from cycle start", ack, 11);
    check(cnt == 1, "R11", "single ack despite write", cnt, 1);
    asN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1, "R11", "cycle ends on snapshot strobe", csN, 1);

    // next cycle uses new option: user only, data strobe, zero waits
    runCycle(24'h000004, 1, 1, 1, 1, 0, 1, cs, ack, cnt, off);
    check(cs == 0, "R11", "supervisor rejected after write", cs, 0);
    runCycle(24'h000004, 1, 1, 1, 0, 0, 1, cs, ack, cnt, off);
    check(cs == 1, "R11", "user accepted after write", cs, 1);
    check(ack == 1, "R11", "new wait code applied", ack, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule